// File: doc/BRIEF.md
# Split-Segment Event Counter with Registered Threshold Hit

This block counts enabled clock cycles in a wide counter that is split into two segments. A narrow, fast low segment advances on every enabled cycle. A wider high segment advances only in the cycle when the low segment rolls over. The two segments together form the full count. Because of the split, no single carry path runs the full width of the counter.

A threshold comparator is placed outside the control logic. It decodes the count value one below the threshold and loads that result into a flag register. The flag is therefore high in exactly the cycles when the count equals the threshold.

A small three-state controller consumes this single flag bit. It never sees the wide count. It waits for a start request, then watches the flag, and reports completion with a one-cycle pulse. Typical uses are timeouts and interval markers in a fast clock domain, where a wide compare inside a state machine would set the critical path.

Top module: `split_counter`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, the count, the hit flag and the done pulse all become 0, and the controller returns to its idle state.
- R2: The low segment (count bits [3:0] by default) increases by one on every clock edge where the enable is high, and wraps from 15 to 0.
- R3: The high segment (count bits [11:4] by default) increases by one only on an edge where the enable is high and the low segment holds 15. On every other edge it keeps its value.
- R4: When the enable is low, the full count holds its value.
- R5: The hit flag is 1 in exactly those cycles in which the count equals the threshold parameter THRESH (default 60). It is a register loaded on enabled cycles from a decode of THRESH-1.
- R6: While the enable is low, the hit flag keeps its value, even while the count rests on the threshold.
- R7: From the all-ones count, one enabled edge returns both segments to zero together, and counting continues from there.
- R8: A start request seen while idle moves the controller into its counting state. While counting, a hit flag of 1 at an edge makes done equal 1 in the following cycle.
- R9: done is never high for two consecutive cycles. After the done cycle the controller is idle, and a start held high during the done cycle is ignored.
- R10: While the controller is idle, the hit flag has no effect: done stays 0 even when the count passes the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| start | input | 1 | Request to arm the controller |
| count | output | LO_W+HI_W | Full count, high segment in the upper bits |
| hit | output | 1 | Registered flag, high while count equals THRESH |
| done | output | 1 | One-cycle completion pulse from the controller |

## Verification
The bench goes after four weak spots:

- **Low-segment rollover.** A high segment that advanced on the wrong low value, or ignored a stall, would drift away from the reference count after the first rollover.
- **Stall at the threshold.** A flag loaded every cycle instead of only on enabled cycles would drop while the count is still resting on the threshold.
- **Full wrap.** A carry that leaked or fell short would not return both segments to zero together.
- **Controller edges.** A start held through the done cycle, and a threshold passed while idle, would show up as a stretched or a spurious done pulse.

// File: rtl/split_counter_pkg.sv
`timescale 1ns/1ps
package split_counter_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } ctl_state_e;

  // Next-state rule of the controller; it takes a single hit bit only.
  function automatic ctl_state_e ctl_next(input ctl_state_e cur,
                                          input logic start,
                                          input logic hit);
    ctl_state_e nxt;
    case (cur)
      S_IDLE:  nxt = start ? S_RUN : S_IDLE;
      S_RUN:   nxt = hit ? S_FIN : S_RUN;
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/sc_low_seg.sv
`timescale 1ns/1ps
module sc_low_seg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  // Carry out: the low segment is about to roll over on this edge.
  assign carry = en && (q == TOP);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= q + ONE;
  end
endmodule

// File: rtl/sc_high_seg.sv
`timescale 1ns/1ps
module sc_high_seg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= q + ONE;
  end
endmodule

// File: rtl/sc_early_flag.sv
`timescale 1ns/1ps
module sc_early_flag #(
  parameter int CW     = 12,
  parameter int THRESH = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  output logic          flag
);
  localparam logic [CW-1:0] PRE = CW'(THRESH - 1);

  // Decode one count early so the registered flag lines up with the threshold.
  function automatic logic pre_match(input logic [CW-1:0] c);
    return c == PRE;
  endfunction

  logic pre_hit;
  assign pre_hit = pre_match(cnt);

  always_ff @(posedge clk) begin
    if (rst)     flag <= 1'b0;
    else if (en) flag <= pre_hit;
  end
endmodule

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
  import split_counter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       hit,
  output ctl_state_e st,
  output logic       done
);
  ctl_state_e nxt;

  // Next-state logic (combinational).
  always_comb nxt = ctl_next(st, start, hit);

  // State register.
  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end

  // Registered output, aligned with the finish state.
  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= (nxt == S_FIN);
  end
endmodule

// File: rtl/split_counter.sv
`timescale 1ns/1ps
module split_counter
  import split_counter_pkg::*;
#(
  parameter int LO_W   = 4,
  parameter int HI_W   = 8,
  parameter int THRESH = 60
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 start,
  output logic [LO_W+HI_W-1:0] count,
  output logic                 hit,
  output logic                 done
);
  localparam int CW = LO_W + HI_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_carry;
  ctl_state_e      st_q;

  sc_low_seg #(.W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .en(en), .q(lo_q), .carry(lo_carry)
  );

  sc_high_seg #(.W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .adv(lo_carry), .q(hi_q)
  );

  assign count = {hi_q, lo_q};

  sc_early_flag #(.CW(CW), .THRESH(THRESH)) u_flag (
    .clk(clk), .rst(rst), .en(en), .cnt(count), .flag(hit)
  );

  sc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .hit(hit), .st(st_q), .done(done)
  );
endmodule

// File: rtl/split_counter_chk.sv
`timescale 1ns/1ps
module split_counter_chk
  import split_counter_pkg::*;
#(
  parameter int LO_W   = 4,
  parameter int HI_W   = 8,
  parameter int THRESH = 60
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [LO_W-1:0] lo,
  input logic [HI_W-1:0] hi,
  input logic            hit,
  input logic            done,
  input ctl_state_e      st
);
  localparam logic [LO_W-1:0]      LO_ONE = LO_W'(1);
  localparam logic [HI_W-1:0]      HI_ONE = HI_W'(1);
  localparam logic [LO_W-1:0]      LO_TOP = {LO_W{1'b1}};
  localparam logic [LO_W+HI_W-1:0] THR_V  = (LO_W+HI_W)'(THRESH);

  // R2
  lo_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> lo == $past(lo) + LO_ONE);

  // R3
  hi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && lo == LO_TOP) |=> hi == $past(hi) + HI_ONE);

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(en && lo == LO_TOP) |=> $stable(hi));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(lo) && $stable(hi) && $stable(hit)));

  // R5
  hit_match_chk: assert property (@(posedge clk) disable iff (rst)
    hit == ({hi, lo} == THR_V));

  // R8
  done_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && hit) |=> done);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |=> !done);
endmodule

bind split_counter split_counter_chk #(
  .LO_W(LO_W), .HI_W(HI_W), .THRESH(THRESH)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .lo(lo_q), .hi(hi_q),
  .hit(hit), .done(done), .st(st_q)
);

// File: tb/split_counter_test.sv
`timescale 1ns/1ps
module split_counter_test;
  localparam int LO_W = 4;
  localparam int HI_W = 8;
  localparam int THR  = 60;
  localparam int CW   = LO_W + HI_W;
  localparam int MODV = 1 << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] count;
  logic hit;
  logic done;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  int ref_cnt = 0;
  int ref_st = 0;   // 0 idle, 1 counting, 2 finished
  bit ref_done = 0;

  always #4 clk = ~clk;

  split_counter #(.LO_W(LO_W), .HI_W(HI_W), .THRESH(THR)) uut (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .count(count), .hit(hit), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(int'(count[LO_W-1:0]) == (ref_cnt % 16), "R2 low segment",
        int'(count[LO_W-1:0]), ref_cnt % 16);
    chk(int'(count[CW-1:LO_W]) == (ref_cnt / 16), "R3 high segment",
        int'(count[CW-1:LO_W]), ref_cnt / 16);
    chk(hit == (ref_cnt == THR), "R5 hit flag", int'(hit), int'(ref_cnt == THR));
    chk(done == ref_done, "R8 done", int'(done), int'(ref_done));
  endtask

  // Called at a falling edge; applies inputs, updates the model at the rising edge.
  task automatic step(input bit e, input bit s);
    bit pre_hit;
    int nst;
    en = e;
    start = s;
    @(posedge clk);
    pre_hit = (ref_cnt == THR);
    case (ref_st)
      0:       nst = s ? 1 : 0;
      1:       nst = pre_hit ? 2 : 1;
      default: nst = 0;
    endcase
    ref_done = (nst == 2);
    ref_st = nst;
    if (e) ref_cnt = (ref_cnt + 1) % MODV;
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en = 1'b0;
    start = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ref_cnt = 0;
    ref_st = 0;
    ref_done = 0;
  endtask

  initial begin
    bit saw_done;
    bit prev_done;
    @(negedge clk);
    do_reset();
    // R1
    chk(count == '0, "R1 count after reset", int'(count), 0);
    chk(hit == 1'b0, "R1 hit after reset", int'(hit), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);

    // R8 with random stalls
    step(1'b0, 1'b1);
    saw_done = 0;
    for (int i = 0; i < 400 && !saw_done; i++) begin
      step($urandom_range(0, 3) != 0, 1'b0);
      if (done) saw_done = 1;
    end
    chk(saw_done, "R8 done observed", int'(saw_done), 1);

    // R4 / R6: rest on the threshold
    do_reset();
    step(1'b1, 1'b1);
    while (ref_cnt != THR) step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0);
      chk(int'(count) == THR, "R4 count holds on stall", int'(count), THR);
      chk(hit == 1'b1, "R6 hit holds on stall", int'(hit), 1);
    end
    step(1'b1, 1'b0);
    chk(hit == 1'b0, "R5 hit drops after threshold", int'(hit), 0);

    // R10: pass the threshold while idle
    do_reset();
    while (ref_cnt != THR + 3) begin
      step(1'b1, 1'b0);
      chk(done == 1'b0, "R10 no done while idle", int'(done), 0);
    end

    // R9: start held high, random stalls
    do_reset();
    prev_done = 0;
    for (int i = 0; i < 300; i++) begin
      step($urandom_range(0, 1) != 0, 1'b1);
      if (prev_done) chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
      prev_done = done;
    end

    // R7: full wrap
    while (ref_cnt != MODV - 1) step(1'b1, 1'b0);
    chk(int'(count) == MODV - 1, "R7 count at all ones", int'(count), MODV - 1);
    step(1'b1, 1'b0);
    chk(count == '0, "R7 wrap to zero", int'(count), 0);
    for (int i = 0; i < 150; i++) step($urandom_range(0, 2) != 0, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule